// File: doc/BRIEF.md
# Wavefront Cross-Lane Permute Network

This block moves 32-bit operands between the 64 lanes of a wavefront in a single pipeline stage. Every destination lane picks one source lane according to a 9-bit control code. The supported movements are permutes inside groups of four lanes, shifts and rotates inside a 16-lane row, one-lane shifts and rotates across the whole wave, mirrors, and broadcasts from a row's last lane. The lanes form 4 rows of 16, and each row is split into 4 banks of 4 lanes.

Alongside the moved data, the block produces a per-lane write-enable. This tells the downstream arithmetic stage whether a lane may be updated. A lane loses its enable in three cases: it sits in a disabled row or bank, its source lies outside the legal range while zero-fill is off, or the control code is not one of the defined codes. When zero-fill is on, an out-of-range source instead gives the value zero, and the lane keeps its enable.

Results are captured one clock after an input strobe and are held until the next strobe.

Top module: `wave_lane_xbar`

## Requirements
- R1: Codes 0x000–0x0FF are group-of-four permutes: the lane at position k (0–3) in its aligned group of four takes the lane of that group whose index is code bits [2k+1:2k].
- R2: Codes 0x101–0x10F shift within a row by n = code[3:0]: row position p takes row position p+n, and is out of range when p+n > 15.
- R3: Codes 0x111–0x11F shift the other way within a row: position p takes p−n, and is out of range when p < n.
- R4: Codes 0x121–0x12F rotate within a row: position p takes (p−n) mod 16, so no lane is ever out of range.
- R5: Whole-wave moves by one lane: 0x130 takes lane L+1 (lane 63 is out of range), 0x138 takes L−1 (lane 0 is out of range), 0x134 takes (L+1) mod 64, and 0x13C takes (L−1) mod 64.
- R6: Code 0x140 takes row position 15−p. Code 0x141 takes position 7−j inside each aligned group of eight lanes, where j is the lane's position in that group.
- R7: Code 0x142 gives every lane of rows 1–3 the value of the last lane of the row below it (lanes 15, 31, 47). Code 0x143 gives every lane of rows 2 and 3 the value of lane 31. Lanes that a broadcast does not target pass their own value.
- R8: For a lane whose source is out of range, the output data is zero. The write-enable of that lane equals the zero-fill input.
- R9: Row enable bit r covers lanes 16r to 16r+15. Bank enable bit b covers lanes whose lane-index bits [3:2] equal b. A lane in a disabled row or bank gets write-enable 0, while its output data still carries the selected source value.
- R10: Every code not listed in R1–R7 (for example 0x100, 0x110, 0x120, 0x131, 0x144–0x1FF) clears all 64 write-enables and gives zero data.
- R11: The out_valid output is high exactly one cycle after in_valid is high. The output data and write-enables load only on a strobe and otherwise hold their values.
- R12: While reset is asserted, out_valid, out_we and out_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; captures a permute result |
| in_data | input | 2048 | 64 lane operands, lane L at bits [32L+31:32L] |
| in_ctrl | input | 9 | Movement control code |
| row_en | input | 4 | Per-row enable |
| bank_en | input | 4 | Per-bank enable, applied in every row |
| zero_fill | input | 1 | Out-of-range sources give zero and stay enabled |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_data | output | 2048 | Permuted lane values |
| out_we | output | 64 | Per-lane write-enable |

## Verification
A wrong source index in one lane's selector shows up as a foreign lane value in exactly that lane's output slot, on the cycle right after the strobe. Each test pattern gives every lane a distinct value, so the offending lane and its actual source can be read straight off the failure line. A wrong row, bank or code-validity decision appears at the same cycle as a flipped bit in out_we. A register that loads without a strobe shows as changed outputs during idle cycles.

// File: rtl/wlx_pkg.sv
package wlx_pkg;

  localparam int CODE_W = 9;

  typedef enum logic [3:0] {
    XOP_QUAD,
    XOP_RSHL,
    XOP_RSHR,
    XOP_RROR,
    XOP_WSHL,
    XOP_WSHR,
    XOP_WROL,
    XOP_WROR,
    XOP_MIRR,
    XOP_HMIRR,
    XOP_BC15,
    XOP_BC31,
    XOP_NONE
  } xop_e;

  typedef struct packed {
    xop_e       op;
    logic [3:0] amt;
    logic [7:0] quad;
  } xctl_t;

endpackage

// File: rtl/wlx_decode.sv
module wlx_decode
  import wlx_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output xctl_t             ctl
);

  always_comb begin
    ctl.op   = XOP_NONE;
    ctl.amt  = code[3:0];
    ctl.quad = code[7:0];
    if (!code[8]) begin
      ctl.op = XOP_QUAD;
    end else begin
      case (code[7:4])
        4'h0: if (code[3:0] != 4'h0) ctl.op = XOP_RSHL;
        4'h1: if (code[3:0] != 4'h0) ctl.op = XOP_RSHR;
        4'h2: if (code[3:0] != 4'h0) ctl.op = XOP_RROR;
        4'h3: begin
          case (code[3:0])
            4'h0:    ctl.op = XOP_WSHL;
            4'h4:    ctl.op = XOP_WROL;
            4'h8:    ctl.op = XOP_WSHR;
            4'hC:    ctl.op = XOP_WROR;
            default: ctl.op = XOP_NONE;
          endcase
        end
        4'h4: begin
          case (code[3:0])
            4'h0:    ctl.op = XOP_MIRR;
            4'h1:    ctl.op = XOP_HMIRR;
            4'h2:    ctl.op = XOP_BC15;
            4'h3:    ctl.op = XOP_BC31;
            default: ctl.op = XOP_NONE;
          endcase
        end
        default: ctl.op = XOP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/wlx_src_sel.sv
module wlx_src_sel
  import wlx_pkg::*;
#(
  parameter int LANE_ID   = 0,
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  localparam int LW       = $clog2(LANES)
) (
  input  xctl_t         ctl,
  output logic [LW-1:0] src,
  output logic          in_range,
  output logic          code_ok
);

  localparam int ROW_IDX = LANE_ID / ROW_LANES;
  localparam int POS     = LANE_ID % ROW_LANES;
  localparam int BASE    = LANE_ID - POS;
  localparam int HALF    = ROW_LANES / 2;
  localparam int HPOS    = LANE_ID % HALF;
  localparam int QPOS    = LANE_ID % 4;
  localparam int QBASE   = LANE_ID - QPOS;

  always_comb begin
    int amt_i;
    int src_i;
    int t;
    amt_i    = int'(ctl.amt);
    src_i    = LANE_ID;
    t        = 0;
    in_range = 1'b1;
    code_ok  = 1'b1;
    case (ctl.op)
      XOP_QUAD:  src_i = QBASE + int'(ctl.quad[2*QPOS +: 2]);
      XOP_RSHL: begin
        t        = POS + amt_i;
        in_range = (t < ROW_LANES);
        src_i    = BASE + t;
      end
      XOP_RSHR: begin
        in_range = (POS >= amt_i);
        src_i    = BASE + POS - amt_i;
      end
      XOP_RROR:  src_i = BASE + ((POS - amt_i + ROW_LANES) % ROW_LANES);
      XOP_WSHL: begin
        in_range = (LANE_ID < LANES - 1);
        src_i    = LANE_ID + 1;
      end
      XOP_WSHR: begin
        in_range = (LANE_ID > 0);
        src_i    = LANE_ID - 1;
      end
      XOP_WROL:  src_i = (LANE_ID + 1) % LANES;
      XOP_WROR:  src_i = (LANE_ID + LANES - 1) % LANES;
      XOP_MIRR:  src_i = BASE + ROW_LANES - 1 - POS;
      XOP_HMIRR: src_i = LANE_ID - HPOS + HALF - 1 - HPOS;
      XOP_BC15:  src_i = (ROW_IDX > 0) ? BASE - 1 : LANE_ID;
      XOP_BC31:  src_i = (ROW_IDX >= 2) ? 2*ROW_LANES - 1 : LANE_ID;
      default: begin
        in_range = 1'b0;
        code_ok  = 1'b0;
      end
    endcase
    if (!in_range) src_i = LANE_ID;
    src = LW'(src_i);
  end

endmodule

// File: rtl/wave_lane_xbar.sv
module wave_lane_xbar
  import wlx_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int DW         = 32,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  localparam int ROWS      = LANES / ROW_LANES,
  localparam int BANKS     = ROW_LANES / BANK_LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [CODE_W-1:0]   in_ctrl,
  input  logic [ROWS-1:0]     row_en,
  input  logic [BANKS-1:0]    bank_en,
  input  logic                zero_fill,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data,
  output logic [LANES-1:0]    out_we
);

  localparam int LW = $clog2(LANES);

  xctl_t            ctl;
  logic [DW-1:0]    lane_val [LANES];
  logic [LANES-1:0] lane_we;

  logic [LANES*DW-1:0] q_data, nxt_data;
  logic [LANES-1:0]    q_we, nxt_we;
  logic                q_valid, nxt_valid;

  wlx_decode u_dec (
    .code (in_ctrl),
    .ctl  (ctl)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int ROW  = l / ROW_LANES;
    localparam int BANK = (l % ROW_LANES) / BANK_LANES;

    logic [LW-1:0] src;
    logic          ok;
    logic          code_ok;

    wlx_src_sel #(
      .LANE_ID   (l),
      .LANES     (LANES),
      .ROW_LANES (ROW_LANES)
    ) u_sel (
      .ctl      (ctl),
      .src      (src),
      .in_range (ok),
      .code_ok  (code_ok)
    );

    assign lane_val[l] = ok ? in_data[int'(src)*DW +: DW] : '0;
    assign lane_we[l]  = code_ok & (ok | zero_fill) & row_en[ROW] & bank_en[BANK];
  end

  always_comb begin
    nxt_valid = in_valid;
    nxt_we    = in_valid ? lane_we : q_we;
    nxt_data  = q_data;
    if (in_valid) begin
      for (int l = 0; l < LANES; l++) nxt_data[l*DW +: DW] = lane_val[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_we    <= '0;
      q_data  <= '0;
    end else begin
      q_valid <= nxt_valid;
      q_we    <= nxt_we;
      q_data  <= nxt_data;
    end
  end

  assign out_valid = q_valid;
  assign out_we    = q_we;
  assign out_data  = q_data;

endmodule

// File: rtl/wave_lane_xbar_chk.sv
module wave_lane_xbar_chk
  import wlx_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int DW         = 32,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  localparam int ROWS      = LANES / ROW_LANES,
  localparam int BANKS     = ROW_LANES / BANK_LANES
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [CODE_W-1:0]   in_ctrl,
  input logic [ROWS-1:0]     row_en,
  input logic [BANKS-1:0]    bank_en,
  input logic                out_valid,
  input logic [LANES*DW-1:0] out_data,
  input logic [LANES-1:0]    out_we
);

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_we)));

  // R9
  row_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && row_en == '0) |=> (out_we == '0));

  // R10
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl == 9'h1FF) |=> (out_we == '0 && out_data == '0));

  // R4
  rotate_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[8:4] == 5'h12 && in_ctrl[3:0] != 4'h0 && (&row_en) && (&bank_en))
      |=> (&out_we));

endmodule

bind wave_lane_xbar wave_lane_xbar_chk #(
  .LANES      (LANES),
  .DW         (DW),
  .ROW_LANES  (ROW_LANES),
  .BANK_LANES (BANK_LANES)
) chk_i (.*);

// File: tb/wave_lane_xbar_tb_top.sv
module wave_lane_xbar_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 64;
  localparam int DW         = 32;
  localparam int NB         = LANES * DW;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [NB-1:0]   in_data;
  logic [8:0]      in_ctrl;
  logic [3:0]      row_en;
  logic [3:0]      bank_en;
  logic            zero_fill;
  logic            out_valid;
  logic [NB-1:0]   out_data;
  logic [63:0]     out_we;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [NB-1:0] exp_d [$];
  logic [63:0]   exp_w [$];
  string         exp_t [$];
  logic [NB-1:0] last_d;
  logic [63:0]   last_w;

  wave_lane_xbar dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ctrl   (in_ctrl),
    .row_en    (row_en),
    .bank_en   (bank_en),
    .zero_fill (zero_fill),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_we    (out_we)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NB-1:0] pattern(input int seed);
    logic [NB-1:0] p;
    for (int l = 0; l < LANES; l++)
      p[l*DW +: DW] = {8'(seed), 8'(l), 8'(l*7 + seed), 8'(~l)};
    return p;
  endfunction

  // Reference: returns expected data and enables from the requirement text.
  task automatic model(input logic [NB-1:0] din, input int c, input logic [3:0] re,
                       input logic [3:0] be, input logic zf,
                       output logic [NB-1:0] d, output logic [63:0] w);
    for (int l = 0; l < LANES; l++) begin
      int r, p, b, n, s;
      bit oor, bad;
      r = l / 16; p = l % 16; b = p / 4; n = c & 15;
      s = l; oor = 0; bad = 0;
      if (c < 256) s = (l / 4) * 4 + ((c >> (2 * (l % 4))) & 3);
      else if (c >= 'h101 && c <= 'h10F) begin if (p + n > 15) oor = 1; else s = l + n; end
      else if (c >= 'h111 && c <= 'h11F) begin if (p < n) oor = 1; else s = l - n; end
      else if (c >= 'h121 && c <= 'h12F) s = r * 16 + (p + 16 - n) % 16;
      else if (c == 'h130) begin if (l == 63) oor = 1; else s = l + 1; end
      else if (c == 'h138) begin if (l == 0) oor = 1; else s = l - 1; end
      else if (c == 'h134) s = (l + 1) % 64;
      else if (c == 'h13C) s = (l + 63) % 64;
      else if (c == 'h140) s = r * 16 + 15 - p;
      else if (c == 'h141) s = (l / 8) * 8 + 7 - (l % 8);
      else if (c == 'h142) s = (r == 0) ? l : r * 16 - 1;
      else if (c == 'h143) s = (r < 2) ? l : 31;
      else bad = 1;
      d[l*DW +: DW] = (bad || oor) ? '0 : din[s*DW +: DW];
      w[l] = !bad && (!oor || zf) && re[r] && be[b];
    end
  endtask

  task automatic send(input int c, input logic [3:0] re, input logic [3:0] be,
                      input logic zf, input int seed, input string tag);
    logic [NB-1:0] din, d;
    logic [63:0]   w;
    din = pattern(seed);
    model(din, c, re, be, zf, d, w);
    @(negedge clk);
    exp_d.push_back(d);
    exp_w.push_back(w);
    exp_t.push_back(tag);
    last_d    = d;
    last_w    = w;
    in_data   = din;
    in_ctrl   = 9'(c);
    row_en    = re;
    bank_en   = be;
    zero_fill = zf;
    in_valid  = 1'b1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input logic [NB-1:0] ad, input logic [63:0] aw,
                         input logic [NB-1:0] ed, input logic [63:0] ew, input string tag);
    checks++;
    if (ad !== ed || aw !== ew) begin
      int bad_l;
      bad_l = 0;
      for (int l = LANES - 1; l >= 0; l--)
        if (ad[l*DW +: DW] !== ed[l*DW +: DW]) bad_l = l;
      errors++;
      $display("FAIL %s: lane %0d data %h exp %h, we %h exp %h", tag, bad_l,
               ad[bad_l*DW +: DW], ed[bad_l*DW +: DW], aw, ew);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_d.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: unexpected out_valid, actual 1 expected 0");
      end else begin
        logic [NB-1:0] d;
        logic [63:0]   w;
        string         t;
        d = exp_d.pop_front();
        w = exp_w.pop_front();
        t = exp_t.pop_front();
        compare(out_data, out_we, d, w, t);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_ctrl = '0;
    row_en = '0; bank_en = '0; zero_fill = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    compare(out_data, out_we, '0, '0, "R12");
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12: out_valid %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(2);

    send('h01B, 4'hF, 4'hF, 0, 1,  "R1 quad reverse");
    send('h0E4, 4'hF, 4'hF, 0, 2,  "R1 quad identity");
    send('h000, 4'hF, 4'hF, 0, 3,  "R1 quad lane0");
    send('h101, 4'hF, 4'hF, 0, 4,  "R2 shift up 1");
    send('h10F, 4'hF, 4'hF, 0, 5,  "R2 shift up 15");
    send('h105, 4'hF, 4'hF, 1, 6,  "R8 shift up 5 zero fill");
    send('h117, 4'hF, 4'hF, 0, 7,  "R3 shift down 7");
    send('h117, 4'hF, 4'hF, 1, 8,  "R8 shift down 7 zero fill");
    send('h128, 4'hF, 4'hF, 0, 9,  "R4 rotate 8");
    send('h121, 4'hF, 4'hF, 0, 10, "R4 rotate 1");
    idle(1);
    send('h130, 4'hF, 4'hF, 0, 11, "R5 wave shift up");
    send('h134, 4'hF, 4'hF, 0, 12, "R5 wave rotate up");
    send('h138, 4'hF, 4'hF, 1, 13, "R5 wave shift down zero fill");
    send('h13C, 4'hF, 4'hF, 0, 14, "R5 wave rotate down");
    send('h140, 4'hF, 4'hF, 0, 15, "R6 row mirror");
    send('h141, 4'hF, 4'hF, 0, 16, "R6 half mirror");
    send('h142, 4'hF, 4'hF, 0, 17, "R7 broadcast last lane");
    send('h143, 4'hF, 4'hF, 0, 18, "R7 broadcast lane 31");
    send('h105, 4'hC, 4'hF, 0, 19, "R9 row mask 1100");
    send('h105, 4'hF, 4'h5, 1, 20, "R9 bank mask 0101");
    send('h140, 4'h0, 4'hF, 0, 21, "R9 all rows off");
    send('h100, 4'hF, 4'hF, 1, 22, "R10 code 0x100");
    send('h131, 4'hF, 4'hF, 1, 23, "R10 code 0x131");
    send('h1FF, 4'hF, 4'hF, 0, 24, "R10 code 0x1FF");
    send('h120, 4'hF, 4'hF, 1, 25, "R10 code 0x120");
    idle(2);

    // R11 hold: inputs move without a strobe, outputs keep the last result
    in_data = pattern(99); in_ctrl = 9'h140; row_en = 4'h0; zero_fill = 1'b1;
    repeat (3) @(negedge clk);
    compare(out_data, out_we, last_d, last_w, "R11 hold without strobe");
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11: out_valid %b expected 0 while idle", out_valid);
    end
    checks++;
    if (exp_d.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d results missing, expected 0", exp_d.size());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule